// File: doc/BRIEF.md
# Programmable Interval Timer with Prescaler

This block is an 8-bit interval timer that counts down on the system clock through a selectable prescaler. A processor loads it with a single register write. The value written becomes the count. The address of that write chooses the divide ratio (1, 8, 64 or 1024) and decides whether the timer may pull the shared interrupt line low.

When the count runs past zero, it wraps to all ones and raises a timer flag. From then on the counter drops by one on every clock, so software can see how long ago the interval expired. Reading the count clears the flag and also reloads the interrupt enable from the address. A separate flag read returns the timer flag together with one externally supplied edge-detect flag bit.

The bus is a plain register access port. A read or a write completes in the cycle it is presented, and there is no back-pressure. Read data is combinational from the current access. The interrupt output is plain control.

Top module: `itimer_top`

## Requirements
- R1: After reset the count is 8'hFF, the divide ratio is 1024, the interrupt enable is off, the timer flag is clear and `irq_n` is high.
- R2: A timer write is `sel`=1, `rsel`=1, `rd_nwr`=0, `addr[4]`=1 and `addr[2]`=1. It loads `wdata` into the count, restarts the prescaler and clears the timer flag. Any other write, including one with `rsel`=0, `sel`=0 or `addr[2]`=0, leaves the count unchanged.
- R3: On a timer write, `addr[1:0]` selects the ratio N: 00 gives 1, 01 gives 8, 10 gives 64 and 11 gives 1024. The count then drops by one after every N clocks.
- R4: When the count is 0 and a decrement is due, the count wraps to 8'hFF and the timer flag sets. While the flag is set, the count drops by one on every clock.
- R5: A timer read is `sel`=1, `rsel`=1, `rd_nwr`=1, `addr[2]`=1 and `addr[0]`=0. It returns the count on `rdata` in the same cycle. At the clock edge it clears the timer flag, unless the flag sets at that same edge.
- R6: A flag read is `sel`=1, `rsel`=1, `rd_nwr`=1, `addr[2]`=1 and `addr[0]`=1. It returns the timer flag in bit 7 and `edge_flag_in` in bit 6, with bits 5..0 at zero, and it has no side effect.
- R7: `irq_n` is low exactly while the timer flag is set and the interrupt enable is on. The enable takes `addr[3]` on every timer write and on every timer read.
- R8: `rdata` is zero in any cycle that is neither a timer read nor a flag read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the prescaler base |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Block selected for this cycle's access |
| rsel | input | 1 | 1 selects the I/O register space, 0 selects memory |
| rd_nwr | input | 1 | 1 for a read, 0 for a write |
| addr | input | 5 | Register address; timer accesses carry ratio and enable here |
| wdata | input | 8 | Write data (the count to load) |
| rdata | output | 8 | Read data: count, flag word, or zero |
| edge_flag_in | input | 1 | External edge-detect flag, shown in flag-read bit 6 |
| irq_n | output | 1 | Active-low interrupt contribution |

## Verification
Several rules are checked by the assertions on every cycle:
- a timer write lands its data in the count on the next cycle;
- a set flag makes the count fall by one per clock;
- the flag can only rise together with a wrap to 8'hFF;
- a write with `addr[3]` low releases `irq_n`;
- a timer read of a non-zero count leaves the flag clear;
- `rdata` idles at zero.

The prescale spacing for each of the four ratios, the exact cycle on which the flag sets, and the enable being picked up by a read only show in the bench scenarios. Those scenarios count clocks from a load and compare the count, the flag word and `irq_n` against values worked out from the ratio.

// File: rtl/itimer_pkg.sv
package itimer_pkg;

  // One decoded bus access for the current cycle.
  typedef struct packed {
    logic       wr_timer;  // load count, ratio and enable
    logic       rd_timer;  // return count, clear flag, update enable
    logic       rd_flags;  // return flag word
    logic [1:0] ratio;     // prescale select carried by the address
    logic       irq_en;    // interrupt enable carried by the address
  } itimer_acc_t;

  localparam int RATIO_SEL_W = 2;
  localparam int RATIO_COUNT = 1 << RATIO_SEL_W;

endpackage

// File: rtl/itimer_decode.sv
module itimer_decode
  import itimer_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              sel,
  input  logic              rsel,
  input  logic              rd_nwr,
  input  logic [ADDR_W-1:0] addr,
  output itimer_acc_t       acc
);

  logic io_sel;

  always_comb begin
    io_sel       = sel && rsel;
    acc.wr_timer = io_sel && !rd_nwr && addr[4] && addr[2];
    acc.rd_timer = io_sel && rd_nwr && addr[2] && !addr[0];
    acc.rd_flags = io_sel && rd_nwr && addr[2] && addr[0];
    acc.ratio    = addr[1:0];
    acc.irq_en   = addr[3];
  end

endmodule

// File: rtl/itimer_prescaler.sv
module itimer_prescaler
  import itimer_pkg::*;
#(
  parameter int SH0 = 0,
  parameter int SH1 = 3,
  parameter int SH2 = 6,
  parameter int SH3 = 10,
  parameter int PRE_W = (SH3 > 0) ? SH3 : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   restart,
  input  logic [RATIO_SEL_W-1:0] ratio,
  input  logic                   fast,
  output logic                   tick
);

  localparam int SHIFTS [RATIO_COUNT] = '{SH0, SH1, SH2, SH3};

  logic [PRE_W-1:0] limit [RATIO_COUNT];
  logic [PRE_W-1:0] pre_q;

  // Terminal count of each ratio: 2^shift - 1.
  for (genvar g = 0; g < RATIO_COUNT; g++) begin : g_limit
    assign limit[g] = PRE_W'((64'd1 << SHIFTS[g]) - 64'd1);
  end

  assign tick = fast || (pre_q == limit[ratio]);

  always_ff @(posedge clk) begin
    if (!rst_n)       pre_q <= '0;
    else if (restart) pre_q <= '0;
    else if (tick)    pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end

endmodule

// File: rtl/itimer_counter.sv
module itimer_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             rd_clr,
  output logic [CNT_W-1:0] count,
  output logic             flag
);

  logic wrap;

  assign wrap = tick && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '1;
      flag  <= 1'b0;
    end else if (load) begin
      count <= load_val;
      flag  <= 1'b0;
    end else begin
      if (tick)        count <= count - 1'b1;
      if (wrap)        flag  <= 1'b1;   // a set in the same edge beats a read clear
      else if (rd_clr) flag  <= 1'b0;
    end
  end

endmodule

// File: rtl/itimer_top.sv
module itimer_top
  import itimer_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 5,
  parameter int SH0    = 0,
  parameter int SH1    = 3,
  parameter int SH2    = 6,
  parameter int SH3    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              rsel,
  input  logic              rd_nwr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  input  logic              edge_flag_in,
  output logic              irq_n
);

  itimer_acc_t            acc;
  logic [RATIO_SEL_W-1:0] ratio_q;
  logic                   ie_q;
  logic                   tick;
  logic [CNT_W-1:0]       count_q;
  logic                   flag_q;

  itimer_decode #(.ADDR_W(ADDR_W)) u_decode (
    .sel    (sel),
    .rsel   (rsel),
    .rd_nwr (rd_nwr),
    .addr   (addr),
    .acc    (acc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratio_q <= '1;
      ie_q    <= 1'b0;
    end else begin
      if (acc.wr_timer)                 ratio_q <= acc.ratio;
      if (acc.wr_timer || acc.rd_timer) ie_q    <= acc.irq_en;
    end
  end

  itimer_prescaler #(.SH0(SH0), .SH1(SH1), .SH2(SH2), .SH3(SH3)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (acc.wr_timer),
    .ratio   (ratio_q),
    .fast    (flag_q),
    .tick    (tick)
  );

  itimer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (acc.wr_timer),
    .load_val (wdata),
    .tick     (tick && !acc.wr_timer),
    .rd_clr   (acc.rd_timer),
    .count    (count_q),
    .flag     (flag_q)
  );

  always_comb begin
    rdata = '0;
    if (acc.rd_timer)      rdata = count_q;
    else if (acc.rd_flags) rdata = {flag_q, edge_flag_in, {(CNT_W-2){1'b0}}};
  end

  assign irq_n = !(flag_q && ie_q);

endmodule

// File: rtl/itimer_checker.sv
module itimer_checker #(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              rsel,
  input logic              rd_nwr,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  wdata,
  input logic [CNT_W-1:0]  rdata,
  input logic              irq_n,
  input logic [CNT_W-1:0]  count_q,
  input logic              flag_q
);

  logic wr_t, rd_t, rd_any;
  assign wr_t   = sel && rsel && !rd_nwr && addr[4] && addr[2];
  assign rd_t   = sel && rsel && rd_nwr && addr[2] && !addr[0];
  assign rd_any = sel && rsel && rd_nwr && addr[2];

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_t |=> (count_q == $past(wdata)));

  assert_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !wr_t) |=> (count_q == $past(count_q) - 1'b1));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> (count_q == '1));

  assert_rdclr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_t && count_q != '0) |=> !flag_q);

  assert_irq_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_t && !addr[3]) |=> irq_n);

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_any |-> (rdata == '0));

endmodule

bind itimer_top itimer_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .sel     (sel),
  .rsel    (rsel),
  .rd_nwr  (rd_nwr),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .irq_n   (irq_n),
  .count_q (count_q),
  .flag_q  (flag_q)
);

// File: tb/itimer_top_tb_top.sv
module itimer_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sel, rsel, rd_nwr, edge_flag_in;
  logic [4:0] addr;
  logic [7:0] wdata, rdata;
  logic       irq_n;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  itimer_top dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel          (sel),
    .rsel         (rsel),
    .rd_nwr       (rd_nwr),
    .addr         (addr),
    .wdata        (wdata),
    .rdata        (rdata),
    .edge_flag_in (edge_flag_in),
    .irq_n        (irq_n)
  );

  typedef struct packed {
    logic [1:0]  ratio;
    logic [7:0]  val;
    logic        ie;
    logic [15:0] waitc;
    logic [7:0]  ecnt;
    logic        eflag;
    logic        eirq_n;
  } vec_t;

  // ratio code, load value, enable, clocks waited, expected count/flag/irq_n
  localparam vec_t VECS [8] = '{
    '{2'b00, 8'd10, 1'b1, 16'd5,    8'd5,   1'b0, 1'b1},
    '{2'b01, 8'd4,  1'b0, 16'd20,   8'd2,   1'b0, 1'b1},
    '{2'b10, 8'd2,  1'b1, 16'd130,  8'd0,   1'b0, 1'b1},
    '{2'b11, 8'd1,  1'b1, 16'd1500, 8'd0,   1'b0, 1'b1},
    '{2'b00, 8'd3,  1'b1, 16'd6,    8'hFD,  1'b1, 1'b0},
    '{2'b01, 8'd0,  1'b0, 16'd10,   8'hFD,  1'b1, 1'b1},
    '{2'b10, 8'd1,  1'b1, 16'd128,  8'hFF,  1'b1, 1'b0},
    '{2'b11, 8'd0,  1'b1, 16'd1023, 8'd0,   1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic rs, input logic rw,
                       input logic [4:0] a, input logic [7:0] d);
    sel = s; rsel = rs; rd_nwr = rw; addr = a; wdata = d;
    #1;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b1, 5'd0, 8'd0);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic timer_wr(input logic [1:0] r, input logic ie, input logic [7:0] v);
    drive(1'b1, 1'b1, 1'b0, {1'b1, ie, 1'b1, r}, v);
    step(1);
    idle();
  endtask

  localparam logic [4:0] FLAG_RD = 5'b00101;

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; edge_flag_in = 1'b0;
    idle();
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    check("R1 irq_n", {7'd0, irq_n}, 8'd1);
    drive(1'b1, 1'b1, 1'b1, FLAG_RD, 8'd0);
    check("R1 flags", rdata, 8'h00);
    drive(1'b1, 1'b1, 1'b1, 5'b00100, 8'd0);
    check("R1 count", rdata, 8'hFF);
    step(1);
    idle();

    // R3 R4 R7 table of ratios and waits
    for (int k = 0; k < 8; k++) begin
      timer_wr(VECS[k].ratio, VECS[k].ie, VECS[k].val);
      step(int'(VECS[k].waitc));
      check("R7 irq_n", {7'd0, irq_n}, {7'd0, VECS[k].eirq_n});
      drive(1'b1, 1'b1, 1'b1, FLAG_RD, 8'd0);
      check("R4 flag", rdata, {VECS[k].eflag, 7'd0});
      drive(1'b1, 1'b1, 1'b1, {1'b0, VECS[k].ie, 3'b100}, 8'd0);
      check("R3 count", rdata, VECS[k].ecnt);
      step(1);
      idle();
    end

    // R5 R7: read clears the flag and picks up the enable from the address
    timer_wr(2'b00, 1'b0, 8'd0);
    step(1);
    drive(1'b1, 1'b1, 1'b1, FLAG_RD, 8'd0);
    check("R4 flag set", rdata, 8'h80);
    check("R7 irq_n disabled", {7'd0, irq_n}, 8'd1);
    drive(1'b1, 1'b1, 1'b1, 5'b01100, 8'd0);
    check("R5 read count", rdata, 8'hFF);
    step(1);
    drive(1'b1, 1'b1, 1'b1, FLAG_RD, 8'd0);
    check("R5 flag cleared", rdata, 8'h00);
    idle();
    step(255);
    check("R7 irq_n enabled by read", {7'd0, irq_n}, 8'd0);

    // R2 write clears flag
    timer_wr(2'b11, 1'b1, 8'd50);
    check("R2 irq_n after write", {7'd0, irq_n}, 8'd1);
    drive(1'b1, 1'b1, 1'b1, FLAG_RD, 8'd0);
    check("R2 flag after write", rdata, 8'h00);
    idle();

    // R2 non-timer writes ignored
    drive(1'b1, 1'b0, 1'b0, 5'b10100, 8'd7);  step(1);
    drive(1'b1, 1'b1, 1'b0, 5'b10000, 8'd9);  step(1);
    drive(1'b0, 1'b1, 1'b0, 5'b10100, 8'd3);  step(1);
    idle();
    drive(1'b1, 1'b1, 1'b1, 5'b01100, 8'd0);
    check("R2 count kept", rdata, 8'd50);
    step(1);

    // R8 unmapped reads
    drive(1'b1, 1'b1, 1'b1, 5'b00000, 8'd0);
    check("R8 rdata unmapped", rdata, 8'h00);
    drive(1'b1, 1'b0, 1'b1, 5'b00100, 8'd0);
    check("R8 rdata memory space", rdata, 8'h00);
    idle();

    // R6 edge flag pass-through
    edge_flag_in = 1'b1;
    drive(1'b1, 1'b1, 1'b1, FLAG_RD, 8'd0);
    check("R6 flag word", rdata, 8'h40);
    step(1);
    drive(1'b1, 1'b1, 1'b1, 5'b01100, 8'd0);
    check("R6 no side effect", rdata, 8'd50);
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule